// File: doc/BRIEF.md
# Dual PS/2 Port Register Controller

This block puts a small register front end in front of two PS/2 ports: a keyboard port and a mouse port. Each port has its own register window. Bit 8 of the byte address selects the window, so the keyboard window starts at the base and the mouse window at base plus 0x100. Software reads an ID, the received data, the control byte and the status byte. It writes the transmit byte and the control byte. The two ports share one interrupt line.

Each port connects to an external PS/2 serial engine through byte streams. Transmit uses a valid/ready handshake. Received bytes arrive on a valid strobe and go into a per-port receive FIFO. The serial engine also reports transmit errors and parity errors on single-cycle pulses. A loopback mode sends a transmitted byte into a one-byte local buffer and raises that port's interrupt without involving the engine. A diagnostic mode lets the direction bits in the control byte drive the two line-shadow bits in the status byte.

Top module: `ps2_dual_regs`

## Requirements
- R1: `bus_addr[8]` selects the port (0 = keyboard, 1 = mouse) and `bus_addr[3:2]` selects the register. A read at offset 0 returns the port ID (0 or 1). Read data appears on `bus_rdata` in the cycle after `bus_rd` is high. In any other cycle `bus_rdata` is 0x00, and an access to one port never changes the other port's registers.
- R2: The control byte (offset 8) resets to 0x00 and reads back exactly the last value written. Its bits are: enable = bit 0, loopback = bit 1, diag = bit 5, data direction = bit 6, clock direction = bit 7.
- R3: In the status byte, bit 7 (clock shadow) and bit 6 (data shadow) read as 1. The exception is when diag is set: each shadow bit then reads as 0 if its direction bit (bit 7 for clock, bit 6 for data) is 0. Status bit 5 always reads 0.
- R4: With loopback set, a write to offset 4 stores the byte locally and sets the port's interrupt and status bit 0. `tx_valid` stays low.
- R5: With loopback set, a read of offset 4 returns the stored byte and clears the port's interrupt and status bit 0.
- R6: With loopback clear, a write to offset 4 drives the byte on the port's `tx_data` lane. `tx_valid` stays high until a cycle in which `tx_ready` is high. Status bit 1 is set while the byte waits.
- R7: Each port has a 16-entry receive FIFO that is filled from the `rx_valid`/`rx_data` stream. With loopback clear, a read of offset 4 pops the bytes in arrival order. A read of an empty FIFO returns 0x00. A byte that arrives while the FIFO holds 16 bytes is dropped. Status bit 0 is set while the FIFO is non-empty.
- R8: With loopback clear, a port's interrupt is high while its FIFO is non-empty. With loopback set, the interrupt follows the local buffer flag. `irq_out` is the OR of both port interrupts, registered one cycle. Status bit 4 of either port reads that OR.
- R9: Status bit 2 (transmit error) and status bit 3 (parity error) are sticky, set by pulses from the engine. A status read clears them. An error pulse in the same cycle as that read wins.
- R10: Writes to offset 0 and offset 12 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 9 | Byte address; bit 8 selects the port, bits 3:2 select the register |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after bus_rd |
| irq_out | output | 1 | Shared interrupt, OR of both ports |
| rx_valid | input | 2 | Received byte strobe per port (bit 0 keyboard) |
| rx_data | input | 16 | Received byte per port (bits 7:0 keyboard) |
| tx_valid | output | 2 | Transmit byte pending per port |
| tx_data | output | 16 | Transmit byte per port |
| tx_ready | input | 2 | Engine accepts the pending byte |
| tx_err | input | 2 | Transmit error pulse per port |
| rx_perr | input | 2 | Parity error pulse per port |

## Verification
Any lost or extra entry in the FIFO count shows as a wrong byte or a wrong status bit 0 on the very next read of that port. It also shows one cycle later as a wrong level on `irq_out`. A stale loopback flag or a wrong ctrl bit changes `irq_out` and the status byte at once, and a loopback write that leaks to the engine raises `tx_valid` in the next cycle. The reference model checks `tx_valid`, `tx_data`, `irq_out` and `bus_rdata` on every clock. A fault therefore shows within two cycles of the access that exposes it.

// File: rtl/ps2r_pkg.sv
package ps2r_pkg;
  // register offsets, bus_addr[3:2]
  localparam logic [1:0] OFS_ID   = 2'd0;  // read: port ID, write: no effect
  localparam logic [1:0] OFS_DATA = 2'd1;  // read: receive byte, write: transmit byte
  localparam logic [1:0] OFS_CTRL = 2'd2;
  localparam logic [1:0] OFS_STAT = 2'd3;  // read only

  // control byte bit positions
  localparam int CB_EN     = 0;
  localparam int CB_LOOP   = 1;
  localparam int CB_DIAG   = 5;
  localparam int CB_DATDIR = 6;
  localparam int CB_CLKDIR = 7;

  // status byte bit positions
  localparam int SB_RXNE   = 0;
  localparam int SB_TXNE   = 1;
  localparam int SB_TXERR  = 2;
  localparam int SB_PERR   = 3;
  localparam int SB_ANYIRQ = 4;
  localparam int SB_DATSHD = 6;
  localparam int SB_CLKSHD = 7;
endpackage

// File: rtl/ps2r_rx_fifo.sv
module ps2r_rx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [DW-1:0]    din,
  input  logic             pop,
  output logic [DW-1:0]    dout,
  output logic             empty,
  output logic             full,
  output logic [LVL_W-1:0] level
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;

  assign empty = (level == '0);
  assign full  = (level == LVL_W'(DEPTH));
  assign dout  = mem[rp];

  // storage array: no reset, single write port
  always_ff @(posedge clk) begin
    if (push && !full) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
      case ({push && !full, pop && !empty})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/ps2r_port.sv
module ps2r_port
  import ps2r_pkg::*;
#(
  parameter int DW      = 8,
  parameter int DEPTH   = 16,
  parameter int PORT_ID = 0,
  parameter int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       reg_sel,
  input  logic [DW-1:0]    wdata,
  input  logic             any_irq,
  output logic [DW-1:0]    rd_val,
  output logic             irq,
  output logic             lb_mode,
  input  logic             rx_valid,
  input  logic [DW-1:0]    rx_data,
  output logic             tx_valid,
  output logic [DW-1:0]    tx_data,
  input  logic             tx_ready,
  input  logic             tx_err,
  input  logic             rx_perr,
  output logic [LVL_W-1:0] rx_level
);
  logic [DW-1:0] ctrl, lb_buf, fifo_dout, status;
  logic          lb_full, terr, perr, fifo_empty, fifo_full, fifo_pop, stat_clr;

  assign lb_mode  = ctrl[CB_LOOP];
  assign fifo_pop = rd_en && (reg_sel == OFS_DATA) && !lb_mode;
  assign stat_clr = rd_en && (reg_sel == OFS_STAT);
  assign irq      = lb_mode ? lb_full : !fifo_empty;

  ps2r_rx_fifo #(.DW(DW), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_fifo (
    .clk  (clk),
    .rst  (rst),
    .push (rx_valid),
    .din  (rx_data),
    .pop  (fifo_pop),
    .dout (fifo_dout),
    .empty(fifo_empty),
    .full (fifo_full),
    .level(rx_level)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      lb_buf   <= '0;
      lb_full  <= 1'b0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
      terr     <= 1'b0;
      perr     <= 1'b0;
    end else begin
      if (tx_valid && tx_ready) tx_valid <= 1'b0;
      if (rd_en && (reg_sel == OFS_DATA) && lb_mode) lb_full <= 1'b0;
      if (wr_en) begin
        case (reg_sel)
          OFS_DATA: begin
            if (lb_mode) begin
              lb_buf  <= wdata;
              lb_full <= 1'b1;
            end else begin
              tx_data  <= wdata;
              tx_valid <= 1'b1;
            end
          end
          OFS_CTRL: ctrl <= wdata;
          default:  ;
        endcase
      end
      terr <= (terr && !stat_clr) || tx_err;
      perr <= (perr && !stat_clr) || rx_perr;
    end
  end

  always_comb begin
    status             = '0;
    status[SB_RXNE]    = lb_mode ? lb_full : !fifo_empty;
    status[SB_TXNE]    = tx_valid;
    status[SB_TXERR]   = terr;
    status[SB_PERR]    = perr;
    status[SB_ANYIRQ]  = any_irq;
    status[SB_DATSHD]  = !(ctrl[CB_DIAG] && !ctrl[CB_DATDIR]);
    status[SB_CLKSHD]  = !(ctrl[CB_DIAG] && !ctrl[CB_CLKDIR]);
  end

  always_comb begin
    case (reg_sel)
      OFS_ID:   rd_val = DW'(PORT_ID);
      OFS_DATA: rd_val = lb_mode ? lb_buf : (fifo_empty ? '0 : fifo_dout);
      OFS_CTRL: rd_val = ctrl;
      default:  rd_val = status;
    endcase
  end

  logic unused_ok;
  assign unused_ok = ctrl[CB_EN] ^ fifo_full;
endmodule

// File: rtl/ps2_dual_regs.sv
module ps2_dual_regs #(
  parameter int DW       = 8,
  parameter int NPORT    = 2,
  parameter int RX_DEPTH = 16,
  parameter int WIN_BIT  = 8,
  parameter int ADDR_W   = 9,
  localparam int SEL_W   = ADDR_W - WIN_BIT,
  localparam int LVL_W   = $clog2(RX_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  output logic                irq_out,
  input  logic [NPORT-1:0]    rx_valid,
  input  logic [NPORT*DW-1:0] rx_data,
  output logic [NPORT-1:0]    tx_valid,
  output logic [NPORT*DW-1:0] tx_data,
  input  logic [NPORT-1:0]    tx_ready,
  input  logic [NPORT-1:0]    tx_err,
  input  logic [NPORT-1:0]    rx_perr
);
  logic [SEL_W-1:0]       port_idx;
  logic [1:0]             reg_sel;
  logic [NPORT-1:0]       port_irq, port_lb;
  logic [DW-1:0]          rd_vals [NPORT];
  logic [DW-1:0]          sel_val;
  logic [NPORT*LVL_W-1:0] rx_level;
  logic                   any_irq;

  assign port_idx = bus_addr[ADDR_W-1:WIN_BIT];
  assign reg_sel  = bus_addr[3:2];
  assign any_irq  = |port_irq;

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    logic hit;
    assign hit = (port_idx == SEL_W'(i));
    ps2r_port #(.DW(DW), .DEPTH(RX_DEPTH), .PORT_ID(i), .LVL_W(LVL_W)) u_port (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (bus_wr && hit),
      .rd_en   (bus_rd && hit),
      .reg_sel (reg_sel),
      .wdata   (bus_wdata),
      .any_irq (any_irq),
      .rd_val  (rd_vals[i]),
      .irq     (port_irq[i]),
      .lb_mode (port_lb[i]),
      .rx_valid(rx_valid[i]),
      .rx_data (rx_data[i*DW +: DW]),
      .tx_valid(tx_valid[i]),
      .tx_data (tx_data[i*DW +: DW]),
      .tx_ready(tx_ready[i]),
      .tx_err  (tx_err[i]),
      .rx_perr (rx_perr[i]),
      .rx_level(rx_level[i*LVL_W +: LVL_W])
    );
  end

  always_comb begin
    sel_val = '0;
    for (int i = 0; i < NPORT; i++)
      if (port_idx == SEL_W'(i)) sel_val = rd_vals[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      bus_rdata <= bus_rd ? sel_val : '0;
      irq_out   <= any_irq;
    end
  end
endmodule

// File: rtl/ps2r_chk.sv
module ps2r_chk #(
  parameter int DW     = 8,
  parameter int NPORT  = 2,
  parameter int DEPTH  = 16,
  parameter int LVL_W  = 5,
  parameter int ADDR_W = 9,
  parameter int SEL_W  = 1
) (
  input logic                   clk,
  input logic                   rst,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic                   bus_wr,
  input logic                   bus_rd,
  input logic [DW-1:0]          bus_rdata,
  input logic                   irq_out,
  input logic [NPORT-1:0]       port_irq,
  input logic [NPORT-1:0]       port_lb,
  input logic [NPORT-1:0]       tx_valid,
  input logic [NPORT-1:0]       tx_ready,
  input logic [NPORT*LVL_W-1:0] rx_level
);
  assert_rdata_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> (bus_rdata == '0));

  assert_irq_or_R8: assert property (@(posedge clk) disable iff (rst)
    irq_out == $past(|port_irq));

  for (genvar i = 0; i < NPORT; i++) begin : g_chk
    logic lb_tx_wr;
    assign lb_tx_wr = bus_wr && (bus_addr[ADDR_W-1:ADDR_W-SEL_W] == SEL_W'(i))
                      && (bus_addr[3:2] == 2'd1) && port_lb[i];

    assert_tx_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (tx_valid[i] && !tx_ready[i]) |=> tx_valid[i]);

    assert_lb_no_tx_R4: assert property (@(posedge clk) disable iff (rst)
      (lb_tx_wr && !tx_valid[i]) |=> !tx_valid[i]);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
      rx_level[i*LVL_W +: LVL_W] <= LVL_W'(DEPTH));
  end
endmodule

bind ps2_dual_regs ps2r_chk #(
  .DW(DW), .NPORT(NPORT), .DEPTH(RX_DEPTH), .LVL_W(LVL_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_rdata(bus_rdata),
  .irq_out  (irq_out),
  .port_irq (port_irq),
  .port_lb  (port_lb),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .rx_level (rx_level)
);

// File: tb/ps2_dual_regs_tb.sv
module ps2_dual_regs_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [8:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq_out;
  logic [1:0]  rx_valid = '0, tx_ready = '0, tx_err = '0, rx_perr = '0;
  logic [15:0] rx_data = '0;
  logic [1:0]  tx_valid;
  logic [15:0] tx_data;

  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  ps2_dual_regs u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .tx_err(tx_err), .rx_perr(rx_perr)
  );

  // ---------------- behavioural reference model ----------------
  byte unsigned q0[$], q1[$];
  logic [7:0] m_ctrl[2], m_lb[2], m_txd[2];
  bit         m_lbf[2], m_txp[2], m_terr[2], m_perr[2];
  bit         m_irq;
  logic [7:0] m_rdata;
  string      m_tag;

  function automatic int qsize(int p);
    return (p == 0) ? q0.size() : q1.size();
  endfunction

  function automatic logic [7:0] qhead(int p);
    if (qsize(p) == 0) return 8'h00;
    return (p == 0) ? q0[0] : q1[0];
  endfunction

  function automatic bit pirq(int p);
    return m_ctrl[p][1] ? m_lbf[p] : (qsize(p) > 0);
  endfunction

  function automatic logic [7:0] mstat(int p);
    logic [7:0] s;
    s    = 8'hC0;
    if (m_ctrl[p][5] && !m_ctrl[p][6]) s[6] = 1'b0;
    if (m_ctrl[p][5] && !m_ctrl[p][7]) s[7] = 1'b0;
    s[0] = m_ctrl[p][1] ? m_lbf[p] : (qsize(p) > 0);
    s[1] = m_txp[p];
    s[2] = m_terr[p];
    s[3] = m_perr[p];
    s[4] = pirq(0) | pirq(1);
    return s;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q0.delete(); q1.delete();
      for (int p = 0; p < 2; p++) begin
        m_ctrl[p] = 0; m_lb[p] = 0; m_txd[p] = 0;
        m_lbf[p] = 0; m_txp[p] = 0; m_terr[p] = 0; m_perr[p] = 0;
      end
      m_irq = 0; m_rdata = 0; m_tag = "R1";
    end else begin
      int ap, off;
      bit nirq, was_full[2];
      ap   = bus_addr[8];
      off  = bus_addr[3:2];
      nirq = pirq(0) | pirq(1);
      m_rdata = 8'h00;
      m_tag   = "R1";
      if (bus_rd) begin
        case (off)
          0: begin m_rdata = 8'(ap); m_tag = "R1"; end
          1: begin m_rdata = m_ctrl[ap][1] ? m_lb[ap] : qhead(ap); m_tag = "R7"; end
          2: begin m_rdata = m_ctrl[ap]; m_tag = "R2"; end
          default: begin m_rdata = mstat(ap); m_tag = "R3"; end
        endcase
      end
      for (int p = 0; p < 2; p++) begin
        was_full[p] = (qsize(p) == 16);
        if (m_txp[p] && tx_ready[p]) m_txp[p] = 0;
        m_terr[p] = (m_terr[p] && !(bus_rd && ap == p && off == 3)) || tx_err[p];
        m_perr[p] = (m_perr[p] && !(bus_rd && ap == p && off == 3)) || rx_perr[p];
      end
      if (bus_rd && off == 1) begin
        if (m_ctrl[ap][1]) m_lbf[ap] = 0;
        else if (qsize(ap) > 0) begin
          if (ap == 0) void'(q0.pop_front()); else void'(q1.pop_front());
        end
      end
      if (bus_wr && off == 1) begin
        if (m_ctrl[ap][1]) begin m_lb[ap] = bus_wdata; m_lbf[ap] = 1; end
        else begin m_txd[ap] = bus_wdata; m_txp[ap] = 1; end
      end
      if (bus_wr && off == 2) m_ctrl[ap] = bus_wdata;
      if (rx_valid[0] && !was_full[0]) q0.push_back(rx_data[7:0]);
      if (rx_valid[1] && !was_full[1]) q1.push_back(rx_data[15:8]);
      m_irq = nirq;
    end
  end

  // ---------------- per-cycle comparison ----------------
  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check(irq_out === m_irq, "R8", 16'(irq_out), 16'(m_irq));
      check(bus_rdata === m_rdata, m_tag, 16'(bus_rdata), 16'(m_rdata));
      for (int p = 0; p < 2; p++) begin
        check(tx_valid[p] === m_txp[p], "R6", 16'(tx_valid[p]), 16'(m_txp[p]));
        if (m_txp[p]) check(tx_data[p*8 +: 8] === m_txd[p], "R6", 16'(tx_data[p*8 +: 8]), 16'(m_txd[p]));
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic do_write(input logic [8:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [8:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check(bus_rdata === exp, req, 16'(bus_rdata), 16'(exp));
  endtask

  task automatic push_bytes(input int p, input logic [7:0] first, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_valid[p] = 1'b1;
      rx_data[p*8 +: 8] = first + 8'(k);
    end
    @(negedge clk);
    rx_valid[p] = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    check(bus_rdata === 8'h00 && irq_out === 1'b0 && tx_valid === 2'b00, "R1", 16'(bus_rdata), 16'h0);

    // R1 IDs, R2 control reset and read-back
    do_read(9'h000, 8'h00, "R1");
    do_read(9'h100, 8'h01, "R1");
    do_read(9'h008, 8'h00, "R2");
    do_write(9'h008, 8'hA5);
    do_read(9'h008, 8'hA5, "R2");
    do_read(9'h108, 8'h00, "R1");

    // R3 shadow bits
    do_read(9'h00C, 8'h80, "R3");
    do_read(9'h10C, 8'hC0, "R3");
    do_write(9'h008, 8'hE0);
    do_read(9'h00C, 8'hC0, "R3");
    do_write(9'h008, 8'h60);
    do_read(9'h00C, 8'h40, "R3");
    do_write(9'h008, 8'h20);
    do_read(9'h00C, 8'h00, "R3");

    // R6 normal transmit with back-pressure
    do_write(9'h008, 8'h01);
    do_write(9'h004, 8'h3C);
    check(tx_valid[0] === 1'b1 && tx_data[7:0] === 8'h3C, "R6", tx_data, 16'h003C);
    do_read(9'h00C, 8'hC2, "R6");
    idle(3);
    check(tx_valid[0] === 1'b1, "R6", 16'(tx_valid), 16'h1);
    tx_ready[0] = 1'b1;
    @(negedge clk);
    tx_ready[0] = 1'b0;
    check(tx_valid[0] === 1'b0, "R6", 16'(tx_valid), 16'h0);

    // R10 ignored write offsets
    do_write(9'h000, 8'hFF);
    do_write(9'h00C, 8'hFF);
    do_read(9'h008, 8'h01, "R10");
    do_read(9'h00C, 8'hC0, "R10");
    check(tx_valid === 2'b00, "R10", 16'(tx_valid), 16'h0);

    // R4/R5 loopback on the mouse port
    do_write(9'h108, 8'h03);
    do_write(9'h104, 8'h5A);
    check(tx_valid[1] === 1'b0, "R4", 16'(tx_valid), 16'h0);
    @(negedge clk);
    check(irq_out === 1'b1, "R4", 16'(irq_out), 16'h1);
    do_read(9'h10C, 8'hD1, "R4");
    do_read(9'h00C, 8'hD0, "R8");
    do_read(9'h104, 8'h5A, "R5");
    do_read(9'h10C, 8'hC0, "R5");
    @(negedge clk);
    check(irq_out === 1'b0, "R5", 16'(irq_out), 16'h0);

    // R8 FIFO data does not interrupt in loopback, does once loopback clears
    push_bytes(1, 8'h77, 1);
    idle(2);
    check(irq_out === 1'b0, "R8", 16'(irq_out), 16'h0);
    do_write(9'h108, 8'h01);
    @(negedge clk);
    check(irq_out === 1'b1, "R8", 16'(irq_out), 16'h1);
    do_read(9'h104, 8'h77, "R7");

    // R7 ordering and empty read on the keyboard port
    push_bytes(0, 8'h11, 3);
    do_read(9'h00C, 8'hD1, "R7");
    do_read(9'h004, 8'h11, "R7");
    do_read(9'h004, 8'h12, "R7");
    do_read(9'h004, 8'h13, "R7");
    do_read(9'h004, 8'h00, "R7");
    do_read(9'h00C, 8'hC0, "R7");

    // R7 fill past depth: 17th byte dropped
    push_bytes(0, 8'h40, 17);
    for (int k = 0; k < 16; k++) do_read(9'h004, 8'h40 + 8'(k), "R7");
    do_read(9'h004, 8'h00, "R7");

    // R9 sticky error bits
    @(negedge clk); tx_err[0] = 1'b1;
    @(negedge clk); tx_err[0] = 1'b0;
    do_read(9'h00C, 8'hC4, "R9");
    do_read(9'h00C, 8'hC0, "R9");
    @(negedge clk); rx_perr[1] = 1'b1;
    @(negedge clk); rx_perr[1] = 1'b0;
    do_read(9'h10C, 8'hC8, "R9");
    do_read(9'h10C, 8'hC0, "R9");

    idle(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule